// File: doc/BRIEF.md
# Link Controller Bring-up Sequencer

This block brings a serial-link controller and its PHY out of reset in a fixed, timed order. A one-cycle pulse on `start_i` opens the hold phase. The PHY is kept powered down, its reference clock stays gated and training stays disabled, while an active-low external reset line is driven low for a programmed number of cycles. After the line is released, the block drives a set of constant PHY tuning values. It then raises the power-enable output, lifts power-down and enables the reference clock. The functional clocks follow one at a time, and each waits for its own acknowledge before the next is enabled.

When every clock is running, the block waits out a settle window and raises training-enable. It then samples the link-up input at fixed intervals, up to a bounded number of times. A one-cycle `done_o` pulse ends each sequence, and `fail_o` is valid in the same cycle. Two things set `fail_o`: an acknowledge that stays low beyond its timeout, or a link that never comes up. After an acknowledge timeout, the clocks already enabled are switched off in reverse order, one per cycle, before `done_o`. All delays are parameters in clock cycles, so a test can use short values.

Top module: `lnk_bringup`

## Requirements
- R1: After reset, `phy_pd_o`=1 and `ext_rst_no`=1. `ref_clk_en_o`, `clk_en_o`, `pwr_en_o`, `train_en_o`, `done_o`, `fail_o` and every tuning output are 0, and they stay so while `start_i` stays low.
- R2: `start_i` is accepted only while idle or finished. The cycle after it is accepted, `ext_rst_no` goes low and stays low for exactly RST_CYC cycles. While it is low, `phy_pd_o`=1 and `ref_clk_en_o`, `train_en_o` and `clk_en_o` are 0.
- R3: The tuning outputs go from 0 to their values one cycle after `ext_rst_no` rises, and they are valid before `phy_pd_o` falls. The values are device type 4, loss-of-signal level 9, Gen1 de-emphasis 0, Gen2 3.5 dB de-emphasis 0, Gen2 6 dB de-emphasis 20, full swing 127 and low swing 127.
- R4: The release steps happen in strictly later cycles, in this order: `pwr_en_o` rises, `phy_pd_o` falls, `ref_clk_en_o` rises, then `clk_en_o[0]` to `clk_en_o[N_CLK-1]` rise in index order. Bit i+1 is enabled only after `clk_ack_i[i]` has been seen high, and at most one enable bit changes per cycle.
- R5: `train_en_o` rises at least SETTLE_CYC cycles after the last clock enable rises, and only when all clock enables are high.
- R6: `link_up_i` is sampled every POLL_GAP_CYC cycles after `train_en_o` rises. At the first sample that finds it high, `done_o` pulses for one cycle with `fail_o`=0.
- R7: If POLL_MAX samples all find `link_up_i` low, `done_o` pulses with `fail_o`=1 exactly POLL_MAX*POLL_GAP_CYC cycles after `train_en_o` rises.
- R8: If `clk_ack_i[k]` is still low ACK_TO_CYC cycles after `clk_en_o[k]` rises, the enables k down to 0 fall one per cycle starting at ACK_TO_CYC+1 cycles after that rise. `done_o` and `fail_o` rise together with the fall of bit 0. Training is never enabled and higher clocks are never enabled. An acknowledge seen ACK_TO_CYC-1 cycles after the enable still counts as on time.
- R9: A `start_i` pulse during a running sequence has no effect: the external reset does not fall again and completion timing is unchanged.
- R10: After `done_o`, `fail_o` holds its value until the next accepted start. After a success, `train_en_o` and all clock enables stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse |
| clk_ack_i | input | N_CLK | Per-clock running acknowledge |
| link_up_i | input | 1 | Link-up status from the controller |
| phy_pd_o | output | 1 | PHY power-down |
| ref_clk_en_o | output | 1 | PHY reference clock enable |
| clk_en_o | output | N_CLK | Per-clock enables, bit 0 first |
| ext_rst_no | output | 1 | External reset, active low |
| pwr_en_o | output | 1 | Slot power enable |
| train_en_o | output | 1 | Link-training enable |
| dev_type_o | output | 4 | Tuning: device type |
| los_lvl_o | output | 5 | Tuning: loss-of-signal level |
| deemph_g1_o | output | 6 | Tuning: Gen1 de-emphasis |
| deemph_g2a_o | output | 6 | Tuning: Gen2 3.5 dB de-emphasis |
| deemph_g2b_o | output | 6 | Tuning: Gen2 6 dB de-emphasis |
| swing_full_o | output | 7 | Tuning: full swing |
| swing_low_o | output | 7 | Tuning: low swing |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Failure flag, valid with done_o |

## Verification
The single-step property on the clock enables assumes that every mass clear of the enables is caused by a start pulse in the previous cycle. The stimulus therefore only starts a new run once a sequence has finished, or, in the busy case, while the block must ignore the pulse. The bench models each acknowledge as a copy of its own enable delayed by a chosen number of cycles. It never raises an acknowledge for a clock that is off. It raises `link_up_i` only after training is enabled and then holds it high, so each poll outcome is fixed by the chosen delay.

// File: rtl/lnk_bringup_pkg.sv
package lnk_bringup_pkg;
  localparam int DEV_W   = 4;
  localparam int LOS_W   = 5;
  localparam int DEEMP_W = 6;
  localparam int SWING_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD, ST_CFG, ST_PWR, ST_UNPD, ST_REF,
    ST_CLK, ST_WAIT, ST_SETTLE, ST_POLL, ST_UNWIND, ST_FIN
  } seq_st_e;
endpackage

// File: rtl/lnk_bringup_timer.sv
module lnk_bringup_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == limit_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || hit_o)    cnt_q <= '0;
    else                         cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/lnk_bringup_clk_chain.sv
module lnk_bringup_clk_chain #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         adv_i,
  input  logic         off_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] clk_en_o,
  output logic         ack_o,
  output logic         last_o,
  output logic         first_o
);
  logic [IW-1:0] idx_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          clk_en_o[i] <= 1'b0;
      else if (clr_i)                       clk_en_o[i] <= 1'b0;
      else if (en_i  && idx_q == IW'(i))    clk_en_o[i] <= 1'b1;
      else if (off_i && idx_q == IW'(i))    clk_en_o[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    idx_q <= '0;
    else if (clr_i)                 idx_q <= '0;
    else if (adv_i)                 idx_q <= idx_q + IW'(1);
    else if (off_i && !first_o)     idx_q <= idx_q - IW'(1);
  end

  assign ack_o   = ack_i[idx_q];
  assign last_o  = (idx_q == IW'(N - 1));
  assign first_o = (idx_q == '0);
endmodule

// File: rtl/lnk_bringup_cfg.sv
module lnk_bringup_cfg
  import lnk_bringup_pkg::*;
#(
  parameter logic [DEV_W-1:0]   DEV_TYPE   = 4'd4,
  parameter logic [LOS_W-1:0]   LOS_LVL    = 5'd9,
  parameter logic [DEEMP_W-1:0] DEEMPH_G1  = 6'd0,
  parameter logic [DEEMP_W-1:0] DEEMPH_G2A = 6'd0,
  parameter logic [DEEMP_W-1:0] DEEMPH_G2B = 6'd20,
  parameter logic [SWING_W-1:0] SWING_FULL = 7'd127,
  parameter logic [SWING_W-1:0] SWING_LOW  = 7'd127
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               load_i,
  output logic [DEV_W-1:0]   dev_type_o,
  output logic [LOS_W-1:0]   los_lvl_o,
  output logic [DEEMP_W-1:0] deemph_g1_o,
  output logic [DEEMP_W-1:0] deemph_g2a_o,
  output logic [DEEMP_W-1:0] deemph_g2b_o,
  output logic [SWING_W-1:0] swing_full_o,
  output logic [SWING_W-1:0] swing_low_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || clr_i) begin
      dev_type_o   <= '0;
      los_lvl_o    <= '0;
      deemph_g1_o  <= '0;
      deemph_g2a_o <= '0;
      deemph_g2b_o <= '0;
      swing_full_o <= '0;
      swing_low_o  <= '0;
    end else if (load_i) begin
      dev_type_o   <= DEV_TYPE;
      los_lvl_o    <= LOS_LVL;
      deemph_g1_o  <= DEEMPH_G1;
      deemph_g2a_o <= DEEMPH_G2A;
      deemph_g2b_o <= DEEMPH_G2B;
      swing_full_o <= SWING_FULL;
      swing_low_o  <= SWING_LOW;
    end
  end
endmodule

// File: rtl/lnk_bringup.sv
module lnk_bringup
  import lnk_bringup_pkg::*;
#(
  parameter int N_CLK        = 4,
  parameter int RST_CYC      = 12_500_000,
  parameter int SETTLE_CYC   = 25_000,
  parameter int ACK_TO_CYC   = 1_000,
  parameter int POLL_GAP_CYC = 12_500,
  parameter int POLL_MAX     = 10,
  parameter bit HAS_PWR_EN   = 1'b1,
  parameter logic [DEV_W-1:0]   DEV_TYPE   = 4'd4,
  parameter logic [LOS_W-1:0]   LOS_LVL    = 5'd9,
  parameter logic [DEEMP_W-1:0] DEEMPH_G1  = 6'd0,
  parameter logic [DEEMP_W-1:0] DEEMPH_G2A = 6'd0,
  parameter logic [DEEMP_W-1:0] DEEMPH_G2B = 6'd20,
  parameter logic [SWING_W-1:0] SWING_FULL = 7'd127,
  parameter logic [SWING_W-1:0] SWING_LOW  = 7'd127
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_CLK-1:0]   clk_ack_i,
  input  logic               link_up_i,
  output logic               phy_pd_o,
  output logic               ref_clk_en_o,
  output logic [N_CLK-1:0]   clk_en_o,
  output logic               ext_rst_no,
  output logic               pwr_en_o,
  output logic               train_en_o,
  output logic [DEV_W-1:0]   dev_type_o,
  output logic [LOS_W-1:0]   los_lvl_o,
  output logic [DEEMP_W-1:0] deemph_g1_o,
  output logic [DEEMP_W-1:0] deemph_g2a_o,
  output logic [DEEMP_W-1:0] deemph_g2b_o,
  output logic [SWING_W-1:0] swing_full_o,
  output logic [SWING_W-1:0] swing_low_o,
  output logic               done_o,
  output logic               fail_o
);
  localparam int MAX_A  = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int MAX_B  = (ACK_TO_CYC > POLL_GAP_CYC) ? ACK_TO_CYC : POLL_GAP_CYC;
  localparam int MAX_DL = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW     = $clog2(MAX_DL + 1);
  localparam int PW     = $clog2(POLL_MAX + 1);

  seq_st_e st_q, st_d;
  logic [TW-1:0] tmr_lim;
  logic [PW-1:0] poll_q;
  logic tmr_run, tmr_hit;
  logic go, ch_en, ch_adv, ch_off, ch_ack, ch_last, ch_first, cfg_ld;
  logic fin, fin_fail, poll_inc;
  logic pd_q, ref_q, pwr_q, rstn_q, train_q, done_q, fail_q;

  assign go = ((st_q == ST_IDLE) || (st_q == ST_FIN)) && start_i;

  always_comb begin
    st_d     = st_q;
    tmr_run  = 1'b0;
    tmr_lim  = '0;
    ch_en    = 1'b0;
    ch_adv   = 1'b0;
    ch_off   = 1'b0;
    cfg_ld   = 1'b0;
    fin      = 1'b0;
    fin_fail = 1'b0;
    poll_inc = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_FIN: if (start_i) st_d = ST_HOLD;
      ST_HOLD: begin
        tmr_run = 1'b1;
        tmr_lim = TW'(RST_CYC);
        if (tmr_hit) st_d = ST_CFG;
      end
      ST_CFG: begin
        cfg_ld = 1'b1;
        st_d   = ST_PWR;
      end
      ST_PWR:  st_d = ST_UNPD;
      ST_UNPD: st_d = ST_REF;
      ST_REF:  st_d = ST_CLK;
      ST_CLK: begin
        ch_en = 1'b1;
        st_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (ch_ack) begin
          if (ch_last) st_d = ST_SETTLE;
          else begin
            ch_adv = 1'b1;
            st_d   = ST_CLK;
          end
        end else begin
          tmr_run = 1'b1;
          tmr_lim = TW'(ACK_TO_CYC);
          if (tmr_hit) st_d = ST_UNWIND;
        end
      end
      ST_SETTLE: begin
        tmr_run = 1'b1;
        tmr_lim = TW'(SETTLE_CYC);
        if (tmr_hit) st_d = ST_POLL;
      end
      ST_POLL: begin
        tmr_run = 1'b1;
        tmr_lim = TW'(POLL_GAP_CYC);
        if (tmr_hit) begin
          if (link_up_i) begin
            fin  = 1'b1;
            st_d = ST_FIN;
          end else if (poll_q == PW'(POLL_MAX - 1)) begin
            fin      = 1'b1;
            fin_fail = 1'b1;
            st_d     = ST_FIN;
          end else begin
            poll_inc = 1'b1;
          end
        end
      end
      ST_UNWIND: begin
        ch_off = 1'b1;
        if (ch_first) begin
          fin      = 1'b1;
          fin_fail = 1'b1;
          st_d     = ST_FIN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pd_q    <= 1'b1;
      ref_q   <= 1'b0;
      pwr_q   <= 1'b0;
      rstn_q  <= 1'b1;
      train_q <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      poll_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (go) begin
        pd_q    <= 1'b1;
        ref_q   <= 1'b0;
        pwr_q   <= 1'b0;
        rstn_q  <= 1'b0;
        train_q <= 1'b0;
        fail_q  <= 1'b0;
        poll_q  <= '0;
      end else begin
        if (st_q == ST_HOLD && tmr_hit)   rstn_q  <= 1'b1;
        if (st_q == ST_PWR)               pwr_q   <= 1'b1;
        if (st_q == ST_UNPD)              pd_q    <= 1'b0;
        if (st_q == ST_REF)               ref_q   <= 1'b1;
        if (st_q == ST_SETTLE && tmr_hit) train_q <= 1'b1;
        if (poll_inc)                     poll_q  <= poll_q + PW'(1);
        if (fin)                          fail_q  <= fin_fail;
      end
    end
  end

  lnk_bringup_timer #(.W(TW)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (tmr_run),
    .limit_i (tmr_lim),
    .hit_o   (tmr_hit)
  );

  lnk_bringup_clk_chain #(.N(N_CLK)) i_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (go),
    .en_i     (ch_en),
    .adv_i    (ch_adv),
    .off_i    (ch_off),
    .ack_i    (clk_ack_i),
    .clk_en_o (clk_en_o),
    .ack_o    (ch_ack),
    .last_o   (ch_last),
    .first_o  (ch_first)
  );

  lnk_bringup_cfg #(
    .DEV_TYPE   (DEV_TYPE),
    .LOS_LVL    (LOS_LVL),
    .DEEMPH_G1  (DEEMPH_G1),
    .DEEMPH_G2A (DEEMPH_G2A),
    .DEEMPH_G2B (DEEMPH_G2B),
    .SWING_FULL (SWING_FULL),
    .SWING_LOW  (SWING_LOW)
  ) i_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (go),
    .load_i       (cfg_ld),
    .dev_type_o   (dev_type_o),
    .los_lvl_o    (los_lvl_o),
    .deemph_g1_o  (deemph_g1_o),
    .deemph_g2a_o (deemph_g2a_o),
    .deemph_g2b_o (deemph_g2b_o),
    .swing_full_o (swing_full_o),
    .swing_low_o  (swing_low_o)
  );

  if (HAS_PWR_EN) begin : g_pwr
    assign pwr_en_o = pwr_q;
  end else begin : g_no_pwr
    assign pwr_en_o = 1'b0;
  end

  assign phy_pd_o     = pd_q;
  assign ref_clk_en_o = ref_q;
  assign ext_rst_no   = rstn_q;
  assign train_en_o   = train_q;
  assign done_o       = done_q;
  assign fail_o       = fail_q;
endmodule

// File: rtl/lnk_bringup_chk.sv
module lnk_bringup_chk
  import lnk_bringup_pkg::*;
#(
  parameter int N_CLK = 4,
  parameter logic [DEV_W-1:0] DEV_TYPE = 4'd4,
  parameter logic [LOS_W-1:0] LOS_LVL  = 5'd9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             phy_pd_o,
  input logic             ref_clk_en_o,
  input logic [N_CLK-1:0] clk_en_o,
  input logic             ext_rst_no,
  input logic             train_en_o,
  input logic [DEV_W-1:0] dev_type_o,
  input logic [LOS_W-1:0] los_lvl_o,
  input logic             done_o,
  input logic             fail_o
);
  // R2
  hold_in_ext_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_no |-> (phy_pd_o && !ref_clk_en_o && !train_en_o && clk_en_o == '0));

  // R3
  cfg_before_unpd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phy_pd_o |-> (dev_type_o == DEV_TYPE && los_lvl_o == LOS_LVL));

  // R4
  clk_needs_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clk_en_o) |-> (ref_clk_en_o && !phy_pd_o));

  // R4
  clk_single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> ($countones(clk_en_o ^ $past(clk_en_o)) < 2));

  // R5
  train_after_clks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(train_en_o) |-> (&clk_en_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  fail_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> done_o);
endmodule

bind lnk_bringup lnk_bringup_chk #(
  .N_CLK    (N_CLK),
  .DEV_TYPE (DEV_TYPE),
  .LOS_LVL  (LOS_LVL)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .phy_pd_o     (phy_pd_o),
  .ref_clk_en_o (ref_clk_en_o),
  .clk_en_o     (clk_en_o),
  .ext_rst_no   (ext_rst_no),
  .train_en_o   (train_en_o),
  .dev_type_o   (dev_type_o),
  .los_lvl_o    (los_lvl_o),
  .done_o       (done_o),
  .fail_o       (fail_o)
);

// File: tb/test_lnk_bringup.sv
module test_lnk_bringup;
  localparam int NC   = 4;
  localparam int RST  = 20;
  localparam int SET  = 16;
  localparam int ACK  = 12;
  localparam int GAP  = 8;
  localparam int PMAX = 10;
  localparam int NV   = 10;
  localparam int NEVER = 999_999;

  // {slow clock index, its ack latency, link delay after training, exp fail, exp done offset}
  localparam int VEC [NV][5] = '{
    '{0, 0,     0,    0, 8},
    '{0, 0,     7,    0, 8},
    '{0, 0,     8,    0, 16},
    '{1, 5,     40,   0, 48},
    '{1, 11,    79,   0, 80},
    '{0, 0,     80,   1, 80},
    '{2, 0,     5000, 1, 80},
    '{1, 12,    0,    1, 14},
    '{0, NEVER, 0,    1, 13},
    '{3, NEVER, 0,    1, 16}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [NC-1:0] clk_ack_i = '0;
  logic link_up_i = 1'b0;
  logic phy_pd_o, ref_clk_en_o, ext_rst_no, pwr_en_o, train_en_o, done_o, fail_o;
  logic [NC-1:0] clk_en_o;
  logic [3:0] dev_type_o;
  logic [4:0] los_lvl_o;
  logic [5:0] deemph_g1_o, deemph_g2a_o, deemph_g2b_o;
  logic [6:0] swing_full_o, swing_low_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lnk_bringup #(
    .N_CLK(NC), .RST_CYC(RST), .SETTLE_CYC(SET), .ACK_TO_CYC(ACK),
    .POLL_GAP_CYC(GAP), .POLL_MAX(PMAX)
  ) i_lnk_bringup (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .clk_ack_i(clk_ack_i),
    .link_up_i(link_up_i), .phy_pd_o(phy_pd_o), .ref_clk_en_o(ref_clk_en_o),
    .clk_en_o(clk_en_o), .ext_rst_no(ext_rst_no), .pwr_en_o(pwr_en_o),
    .train_en_o(train_en_o), .dev_type_o(dev_type_o), .los_lvl_o(los_lvl_o),
    .deemph_g1_o(deemph_g1_o), .deemph_g2a_o(deemph_g2a_o),
    .deemph_g2b_o(deemph_g2b_o), .swing_full_o(swing_full_o),
    .swing_low_o(swing_low_o), .done_o(done_o), .fail_o(fail_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic run_case(input int sidx, input int slat, input int link_d,
                          input int exp_fail, input int exp_off, input bit mid_start);
    int r_fall, r_rise, pwr_r, pd_f, ref_r, cfg_r, tr_r, done_c, n_rfall, prev_rst, lat, ref_c;
    int cr[NC];
    int cf[NC];
    bit bad_hold, cfg_ok, fail_seen, tmo;
    r_fall = -1; r_rise = -1; pwr_r = -1; pd_f = -1; ref_r = -1; cfg_r = -1;
    tr_r = -1; done_c = -1; n_rfall = 0; prev_rst = 1;
    bad_hold = 0; cfg_ok = 0; fail_seen = 0;
    tmo = (slat >= ACK);
    for (int j = 0; j < NC; j++) begin cr[j] = -1; cf[j] = -1; end
    @(negedge clk);
    link_up_i = 1'b0;
    clk_ack_i = '0;
    start_i   = 1'b1;
    for (int w = 0; w < 3000 && done_c < 0; w++) begin
      @(negedge clk);
      start_i = mid_start && cr[NC-1] >= 0 && cyc == cr[NC-1] + 3;
      if (!ext_rst_no && prev_rst == 1) begin
        n_rfall++;
        if (r_fall < 0) r_fall = cyc;
      end
      prev_rst = ext_rst_no;
      if (r_fall >= 0 && r_rise < 0 && ext_rst_no) r_rise = cyc;
      if (!ext_rst_no && (!phy_pd_o || ref_clk_en_o || train_en_o || clk_en_o != '0))
        bad_hold = 1;
      if (pwr_r < 0 && pwr_en_o) pwr_r = cyc;
      if (cfg_r < 0 && dev_type_o != 0) cfg_r = cyc;
      if (pd_f < 0 && !phy_pd_o) begin
        pd_f = cyc;
        cfg_ok = dev_type_o == 4 && los_lvl_o == 9 && deemph_g1_o == 0 &&
                 deemph_g2a_o == 0 && deemph_g2b_o == 20 &&
                 swing_full_o == 127 && swing_low_o == 127;
      end
      if (ref_r < 0 && ref_clk_en_o) ref_r = cyc;
      for (int j = 0; j < NC; j++) begin
        if (cr[j] < 0 && clk_en_o[j]) cr[j] = cyc;
        if (cr[j] >= 0 && cf[j] < 0 && !clk_en_o[j]) cf[j] = cyc;
      end
      if (tr_r < 0 && train_en_o) tr_r = cyc;
      if (done_o) begin done_c = cyc; fail_seen = fail_o; end
      for (int j = 0; j < NC; j++) begin
        lat = (j == sidx) ? slat : 0;
        clk_ack_i[j] = clk_en_o[j] && cr[j] >= 0 && (cyc - cr[j] >= lat);
      end
      if (tr_r >= 0 && cyc >= tr_r + link_d) link_up_i = 1'b1;
    end
    start_i = 1'b0;

    check(r_rise - r_fall == RST, "R2 ext reset low width", r_rise - r_fall, RST);
    check(!bad_hold, "R2 hold state during ext reset", bad_hold, 0);
    check(n_rfall == 1, "R9 ext reset fall count", n_rfall, 1);
    check(cfg_r == r_rise + 1, "R3 tuning load cycle", cfg_r, r_rise + 1);
    check(cfg_ok && cfg_r < pd_f, "R3 tuning values before power-down release", cfg_ok, 1);
    check(pwr_r > r_rise && pd_f > pwr_r && ref_r > pd_f && cr[0] > ref_r,
          "R4 power/ref/clk0 order", pd_f - pwr_r, 1);
    for (int j = 0; j + 1 < NC; j++) begin
      if (!tmo || j + 1 <= sidx)
        check(cr[j + 1] > cr[j], "R4 clock enable order", cr[j + 1], cr[j] + 1);
    end
    ref_c = tmo ? cr[sidx] : tr_r;
    check(done_c >= 0 && done_c - ref_c == exp_off, tmo ? "R8 done timing" : (exp_fail ? "R7 done timing" : "R6 done timing"),
          done_c - ref_c, exp_off);
    check(fail_seen == exp_fail, exp_fail ? "R7 fail with done" : "R6 pass with done", fail_seen, exp_fail);
    if (tmo) begin
      for (int j = 0; j <= sidx; j++)
        check(cf[j] - cr[sidx] == ACK + 1 + (sidx - j), "R8 reverse shutdown", cf[j] - cr[sidx], ACK + 1 + (sidx - j));
      for (int j = sidx + 1; j < NC; j++)
        check(cr[j] < 0, "R8 later clock never enabled", cr[j], -1);
      check(tr_r < 0, "R8 training never enabled", tr_r, -1);
    end else begin
      check(tr_r - cr[NC-1] >= SET, "R5 settle window", tr_r - cr[NC-1], SET);
    end
    @(negedge clk);
    check(!done_o, "R6 done one cycle wide", done_o, 0);
    repeat (3) @(negedge clk);
    check(fail_o == exp_fail, "R10 fail held", fail_o, exp_fail);
    if (!exp_fail)
      check(train_en_o && clk_en_o == '1, "R10 running state held", {train_en_o, clk_en_o}, 5'h1f);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(phy_pd_o && ext_rst_no && !ref_clk_en_o && clk_en_o == '0, "R1 state in reset",
          {phy_pd_o, ext_rst_no, ref_clk_en_o, clk_en_o}, 7'h60);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk);
    check(phy_pd_o && ext_rst_no && !ref_clk_en_o && clk_en_o == '0 && !pwr_en_o &&
          !train_en_o && !done_o && !fail_o, "R1 idle outputs",
          {phy_pd_o, ext_rst_no, ref_clk_en_o, pwr_en_o, train_en_o, done_o, fail_o}, 7'h60);
    check(dev_type_o == 0 && los_lvl_o == 0 && deemph_g2b_o == 0 && swing_full_o == 0 &&
          swing_low_o == 0, "R1 tuning outputs cleared", dev_type_o, 0);

    for (int i = 0; i < NV; i++)
      run_case(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 1'b0);

    // R9: start pulse during the settle window is ignored
    run_case(0, 0, 0, 0, 8, 1'b1);
    // R10: restart after a failed run clears fail and runs normally
    run_case(2, NEVER, 0, 1, 15, 1'b0);
    run_case(0, 0, 20, 0, 24, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule